// File: doc/BRIEF.md
# DMA Interrupt Status and Control Register

This block is the single interrupt register shared by seven DMA channels. Software uses it to choose which channels may raise an interrupt and to turn all of them on or off at once. It reads which channels have finished or hit a bus error, and it acknowledges each channel by writing a one to that channel's flag. The transfer engines report to it through one-cycle pulses: one pulse per channel on completion and one per channel on a bus error. The block drives one level-sensitive interrupt line.

A bus error always records itself: it sets a summary error bit and the flag of the channel that failed. A completion sets the channel's flag only when that channel's enable and the global enable are both on. The top bit of the register is a summary bit that software cannot write. It is high when the error bit is set, or when the global enable is on and any channel flag is set. The interrupt line is a copy of this summary bit.

Top module: `dma_irq_ctl`

## Requirements
- R1: A CPU write stores only bits 5:0 (free-use bits), bit 15 (bus-error bit) and bits 23:16; these take the written value. Bits 14:6 always read as zero, whatever is written.
- R2: Writing 1 to a bit in 30:24 clears that channel flag, and writing 0 leaves it unchanged. Bit 31 cannot be written.
- R3: A completion pulse on channel c sets flag bit 24+c only if enable bit 16+c and the global enable bit 23 are both 1. The enables used are the values held before that clock edge.
- R4: A bus-error pulse on channel c sets bit 15 and flag bit 24+c, whatever the enables are.
- R5: Bit 31 reads as bit15 OR (bit23 AND any of bits 30:24). It is updated on the same clock edge as the write or event that changes its inputs.
- R6: The output irq is always equal to bit 31 of the read value.
- R7: A synchronous active-high reset clears the whole register to zero and drives irq low.
- R8: If a hardware set and a CPU write-one-to-clear hit the same flag on the same edge, the flag ends up set. A bus-error pulse also sets bit 15 when the same write stores 0 there.
- R9: Reading has no side effects. With no write and no pulse, the read value stays constant.
- R10: Pulses on several channels in one cycle are each handled by the rules above.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | CPU write strobe for this register |
| wr_data | input | 32 | CPU write data |
| ch_done | input | 7 | Per-channel completion pulses |
| ch_berr | input | 7 | Per-channel bus-error pulses |
| rd_data | output | 32 | Current register value, summary bit included |
| irq | output | 1 | Level interrupt line |

## Verification
Every state bit is a register that the read port shows directly, so any wrong internal state appears on rd_data on the edge after the event that caused it. A flag that is wrongly set or kept also reaches irq on that same edge whenever the global enable is on. A wrongly set error bit reaches irq at once, with no enable involved. The bench therefore compares the full read word and irq after every step. This catches a bad gate, a mask bit in the wrong place, or a clear that loses against a set one cycle after the cause.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int CH_N      = 7;
  localparam int FREE_W    = 6;
  localparam int ERR_POS   = 15;
  localparam int ENA_POS   = 16;
  // reasons a channel flag may be raised in a cycle
  typedef struct packed {
    logic by_err;
    logic by_done;
  } set_cause_t;
endpackage

// File: rtl/irqc_cfg_reg.sv
module irqc_cfg_reg #(
  parameter int NUM_CH = 7,
  parameter int FREE_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [FREE_W-1:0] wr_free,
  input  logic [NUM_CH-1:0] wr_ena,
  input  logic              wr_gen,
  output logic [FREE_W-1:0] free_q,
  output logic [NUM_CH-1:0] ena_q,
  output logic              gen_q,
  output logic              gen_nxt
);
  assign gen_nxt = wr_en ? wr_gen : gen_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      free_q <= '0;
      ena_q  <= '0;
      gen_q  <= 1'b0;
    end else if (wr_en) begin
      free_q <= wr_free;
      ena_q  <= wr_ena;
      gen_q  <= wr_gen;
    end
  end

  // R1: configuration holds without a write
  p_cfg_hold_r1: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> ($stable(free_q) && $stable(ena_q) && $stable(gen_q)));
endmodule

// File: rtl/irqc_flag_bank.sv
module irqc_flag_bank
  import irqc_pkg::*;
#(
  parameter int NUM_CH = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [NUM_CH-1:0] wr_clr,
  input  logic [NUM_CH-1:0] done,
  input  logic [NUM_CH-1:0] berr,
  input  logic [NUM_CH-1:0] ena,
  input  logic              gen,
  output logic [NUM_CH-1:0] flag_q,
  output logic [NUM_CH-1:0] flag_nxt
);
  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    set_cause_t cause;
    logic       kill;
    assign cause.by_err  = berr[c];
    assign cause.by_done = done[c] & ena[c] & gen;
    assign kill          = wr_en & wr_clr[c];
    assign flag_nxt[c]   = (|cause) | (flag_q[c] & ~kill);

    always_ff @(posedge clk) begin
      if (rst) flag_q[c] <= 1'b0;
      else     flag_q[c] <= flag_nxt[c];
    end

    p_err_sets_r4: assert property (@(posedge clk) disable iff (rst)
      berr[c] |=> flag_q[c]);
    p_gated_done_r3: assert property (@(posedge clk) disable iff (rst)
      (!flag_q[c] && !berr[c] && !(ena[c] && gen)) |=> !flag_q[c]);
    p_w1c_r2: assert property (@(posedge clk) disable iff (rst)
      (wr_en && wr_clr[c] && !berr[c] && !done[c]) |=> !flag_q[c]);
    p_set_wins_r8: assert property (@(posedge clk) disable iff (rst)
      (wr_en && wr_clr[c] && done[c] && ena[c] && gen) |=> flag_q[c]);
  end
endmodule

// File: rtl/irqc_summary.sv
module irqc_summary #(
  parameter int NUM_CH = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              wr_err,
  input  logic [NUM_CH-1:0] berr,
  input  logic              gen_nxt,
  input  logic [NUM_CH-1:0] flag_nxt,
  output logic              err_q,
  output logic              sum_q
);
  logic err_nxt;
  logic sum_nxt;

  assign err_nxt = (|berr) | (wr_en ? wr_err : err_q);
  assign sum_nxt = err_nxt | (gen_nxt & (|flag_nxt));

  always_ff @(posedge clk) begin
    if (rst) begin
      err_q <= 1'b0;
      sum_q <= 1'b0;
    end else begin
      err_q <= err_nxt;
      sum_q <= sum_nxt;
    end
  end

  p_err_bit_r4: assert property (@(posedge clk) disable iff (rst)
    (|berr) |=> (err_q && sum_q));
endmodule

// File: rtl/dma_irq_ctl.sv
module dma_irq_ctl #(
  parameter int NUM_CH  = irqc_pkg::CH_N,
  parameter int FREE_W  = irqc_pkg::FREE_W,
  parameter int ERR_POS = irqc_pkg::ERR_POS,
  parameter int ENA_POS = irqc_pkg::ENA_POS,
  localparam int GEN_POS = ENA_POS + NUM_CH,
  localparam int FLG_POS = GEN_POS + 1,
  localparam int SUM_POS = FLG_POS + NUM_CH,
  localparam int DW      = SUM_POS + 1,
  localparam int GAP_W   = ERR_POS - FREE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [DW-1:0]     wr_data,
  input  logic [NUM_CH-1:0] ch_done,
  input  logic [NUM_CH-1:0] ch_berr,
  output logic [DW-1:0]     rd_data,
  output logic              irq
);
  logic [FREE_W-1:0] free_q;
  logic [NUM_CH-1:0] ena_q;
  logic              gen_q;
  logic              gen_nxt;
  logic [NUM_CH-1:0] flag_q;
  logic [NUM_CH-1:0] flag_nxt;
  logic              err_q;
  logic              sum_q;

  irqc_cfg_reg #(.NUM_CH(NUM_CH), .FREE_W(FREE_W)) u_cfg (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_free (wr_data[FREE_W-1:0]),
    .wr_ena  (wr_data[GEN_POS-1:ENA_POS]),
    .wr_gen  (wr_data[GEN_POS]),
    .free_q  (free_q),
    .ena_q   (ena_q),
    .gen_q   (gen_q),
    .gen_nxt (gen_nxt)
  );

  irqc_flag_bank #(.NUM_CH(NUM_CH)) u_flags (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_en),
    .wr_clr   (wr_data[SUM_POS-1:FLG_POS]),
    .done     (ch_done),
    .berr     (ch_berr),
    .ena      (ena_q),
    .gen      (gen_q),
    .flag_q   (flag_q),
    .flag_nxt (flag_nxt)
  );

  irqc_summary #(.NUM_CH(NUM_CH)) u_sum (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_en),
    .wr_err   (wr_data[ERR_POS]),
    .berr     (ch_berr),
    .gen_nxt  (gen_nxt),
    .flag_nxt (flag_nxt),
    .err_q    (err_q),
    .sum_q    (sum_q)
  );

  assign rd_data = {sum_q, flag_q, gen_q, ena_q, err_q, {GAP_W{1'b0}}, free_q};
  assign irq     = sum_q;

  // R5: the summary register agrees with the separately held fields
  p_summary_r5: assert property (@(posedge clk) disable iff (rst)
    rd_data[SUM_POS] == (rd_data[ERR_POS] |
                         (rd_data[GEN_POS] & (|rd_data[SUM_POS-1:FLG_POS]))));
  p_reset_r7: assert property (@(posedge clk)
    rst |=> (rd_data == '0 && !irq));
  p_quiet_r9: assert property (@(posedge clk) disable iff (rst)
    (!wr_en && ch_done == '0 && ch_berr == '0) |=> $stable(rd_data));
endmodule

// File: tb/dma_irq_ctl_bench.sv
module dma_irq_ctl_bench;
  logic        clk = 1'b0;
  logic        rst;
  logic        wr_en;
  logic [31:0] wr_data;
  logic [6:0]  ch_done;
  logic [6:0]  ch_berr;
  logic [31:0] rd_data;
  logic        irq;
  int          checks = 0;
  int          errors = 0;

  always #4 clk = ~clk;

  dma_irq_ctl u_dma_irq_ctl (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
    .ch_done(ch_done), .ch_berr(ch_berr), .rd_data(rd_data), .irq(irq)
  );

  typedef struct packed {
    logic        we;
    logic [31:0] wd;
    logic [6:0]  dn;
    logic [6:0]  be;
    logic [31:0] exp;
  } step_t;

  localparam step_t STEPS [22] = '{
    '{1'b1, 32'hFFFF_FFFF, 7'h00, 7'h00, 32'h80FF_803F}, // R1 mask, R5 err
    '{1'b1, 32'h0000_0000, 7'h00, 7'h00, 32'h0000_0000}, // R1
    '{1'b1, 32'h0081_0000, 7'h00, 7'h00, 32'h0081_0000}, // en ch0 + global
    '{1'b0, 32'h0000_0000, 7'h03, 7'h00, 32'h8181_0000}, // R3 R10 ch0 only
    '{1'b1, 32'h0281_0000, 7'h00, 7'h00, 32'h8181_0000}, // R2 write 0 keeps
    '{1'b1, 32'h0181_0000, 7'h00, 7'h00, 32'h0081_0000}, // R2 clear ch0
    '{1'b0, 32'h0000_0000, 7'h00, 7'h40, 32'hC081_8000}, // R4 ch6
    '{1'b1, 32'h4001_0000, 7'h00, 7'h00, 32'h0001_0000}, // R2 R5
    '{1'b0, 32'h0000_0000, 7'h01, 7'h00, 32'h0001_0000}, // R3 global off
    '{1'b1, 32'h0080_0000, 7'h00, 7'h00, 32'h0080_0000},
    '{1'b0, 32'h0000_0000, 7'h7F, 7'h00, 32'h0080_0000}, // R3 no ch enables
    '{1'b1, 32'h00FE_0000, 7'h00, 7'h00, 32'h00FE_0000},
    '{1'b0, 32'h0000_0000, 7'h05, 7'h00, 32'h84FE_0000}, // R3 R10 ch2
    '{1'b1, 32'h0000_0000, 7'h00, 7'h00, 32'h0400_0000}, // R5 global off
    '{1'b1, 32'h0080_0000, 7'h00, 7'h00, 32'h8480_0000}, // R5 global on
    '{1'b1, 32'h0480_0000, 7'h00, 7'h04, 32'h8480_8000}, // R8 err beats
    '{1'b1, 32'h0400_0000, 7'h00, 7'h00, 32'h0000_0000},
    '{1'b1, 32'h0000_002A, 7'h00, 7'h00, 32'h0000_002A}, // R1 free bits
    '{1'b1, 32'h0000_7FC0, 7'h00, 7'h00, 32'h0000_0000}, // R1 gap bits
    '{1'b1, 32'h8000_0000, 7'h00, 7'h00, 32'h0000_0000}, // R2 bit31
    '{1'b1, 32'h0084_0000, 7'h00, 7'h00, 32'h0084_0000},
    '{1'b1, 32'h0484_0000, 7'h04, 7'h00, 32'h8484_0000}  // R8 done beats
  };

  task automatic check(input string req, input logic [31:0] exp);
    checks++;
    if (rd_data !== exp) begin
      errors++;
      $display("FAIL %s rd_data actual %h expected %h", req, rd_data, exp);
    end
    checks++;
    if (irq !== exp[31]) begin
      errors++;
      $display("FAIL R6 irq actual %b expected %b (%s)", irq, exp[31], req);
    end
  endtask

  task automatic idle();
    wr_en = 1'b0; wr_data = '0; ch_done = '0; ch_berr = '0;
  endtask

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual hung expected done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    idle();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check("R7", 32'h0);
    for (int i = 0; i < 22; i++) begin
      wr_en = STEPS[i].we; wr_data = STEPS[i].wd;
      ch_done = STEPS[i].dn; ch_berr = STEPS[i].be;
      @(negedge clk);
      check($sformatf("R1-step%0d", i), STEPS[i].exp);
    end
    idle();
    // R9: five idle cycles leave the value untouched
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      check("R9", 32'h8484_0000);
    end
    // R10: errors on two channels at once
    ch_berr = 7'h11;
    @(negedge clk);
    idle();
    check("R10", 32'h9584_8000);
    // R7: reset from a busy state
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check("R7", 32'h0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule